// File: doc/BRIEF.md
# Almost-Flag Status Reporter

This block collects the active-low almost-empty (or, in a second instance, almost-full) flags of a group of multi-queue devices. Each device holds four queues, and the block presents the flags of one device at a time on a narrow status bus. A mode input is sampled only while master reset is held, and the choice stays in force until the next master reset.

In direct mode, external logic picks the reported device. It drives a device number and raises a strobe, and the choice takes effect on that rising edge. In polled mode the strobe is ignored. The bus moves to the next device on every rising edge and wraps from the last device back to device 0. A device-index output and a one-hot drive-enable vector name the device whose flags are on the bus. Every device except that one keeps its bus drive turned off.

A separate single-bit output follows the flag of one queue across the whole group. That queue is chosen by a select enable and a flat queue number. The single-bit output works the same way in both modes.

Top module: `afs_status_top`

## Requirements
- R1: The scan mode is taken from `mode_in` only on a clock edge where `rst_n` is low (0 = direct, 1 = polled). Changes on `mode_in` while `rst_n` is high have no effect until the next reset.
- R2: After a reset edge, `bus_dev` is 0, `bus_oe` selects device 0 only, every bit of `bus_flags_n` is 1, and `single_flag_n` is 1.
- R3: In direct mode, an edge with `strobe` high and `dev_addr` below NUM_DEV makes `bus_dev` equal to `dev_addr` after that edge.
- R4: In direct mode, `bus_dev` keeps its value across an edge where `strobe` is low. It also keeps its value across an edge where `strobe` is high and `dev_addr` is NUM_DEV or more.
- R5: In polled mode, `bus_dev` increases by one on every edge and goes from NUM_DEV-1 back to 0. `strobe` and `dev_addr` have no effect.
- R6: After each edge, bit q of `bus_flags_n` equals `flags_n[d*4+q]` as sampled at that edge, where d is the device selected by that same edge. A low bit means the queue is almost empty or almost full.
- R7: `bus_oe` is one-hot, and its set bit is at position `bus_dev`.
- R8: An edge with `sel_en` high and `sel_addr` below NUM_DEV*4 selects queue `sel_addr`. After each edge, `single_flag_n` equals `flags_n` at the selected queue's position, as sampled at that edge.
- R9: An edge with `sel_en` high and `sel_addr` of NUM_DEV*4 or more leaves the selected queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flag clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| mode_in | input | 1 | Scan mode, sampled during reset only (1 = polled) |
| strobe | input | 1 | Direct-mode device select strobe |
| dev_addr | input | IDX_W | Device number for direct selection |
| sel_en | input | 1 | Loads the queue followed by the single flag |
| sel_addr | input | SEL_W | Flat queue number (device*4 + queue) |
| flags_n | input | NUM_DEV*4 | Active-low almost flags of all queues |
| bus_flags_n | output | 4 | Flags of the reported device, active low |
| bus_oe | output | NUM_DEV | One-hot bus drive enable per device |
| bus_dev | output | IDX_W | Index of the reported device |
| single_flag_n | output | 1 | Flag of the selected queue, active low |

## Verification
The hardest cases to reach from the ports are a mode change that arrives after reset and an address that falls past the last device. The default of five devices leaves three unused codes on a 3-bit device number, so these addresses exist at the ports. The stimulus resets once into each mode and toggles `mode_in` at random while reset is released. It drives device and queue numbers across the whole field width, so strobes and selects that must be ignored happen often. Fixed sequences then give a strobe at address 7 and a queue select at 31, and a polled run lasts long enough to wrap several times.

// File: rtl/afs_pkg.sv
// Package: shared types and helpers for the almost-flag status reporter.
// Assumes nothing beyond a single clock domain.
package afs_pkg;

    typedef enum logic {
        SCAN_DIRECT = 1'b0,
        SCAN_POLLED = 1'b1
    } scan_mode_e;

    localparam int unsigned QUEUES_PER_DEV = 4;

endpackage

// File: rtl/afs_mode_latch.sv
// Module: holds the scan mode. It samples mode_in on every edge while
// reset is low and ignores it otherwise.
// Assumes: rst_n is synchronous and active low.
module afs_mode_latch
    import afs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_in,
    output scan_mode_e mode_q
);

    // Capture the mode only during master reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= scan_mode_e'(mode_in);
        end
    end

endmodule

// File: rtl/afs_dev_sequencer.sv
// Module: chooses which device is reported. In direct mode a strobe with
// an in-range address loads the index. In polled mode the index steps by
// one and wraps. dev_next is the value the index takes at the coming edge.
// Assumes: NUM_DEV >= 2.
module afs_dev_sequencer
    import afs_pkg::*;
#(
    parameter int unsigned NUM_DEV = 5,
    parameter int unsigned IDX_W   = $clog2(NUM_DEV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  scan_mode_e       mode,
    input  logic             strobe,
    input  logic [IDX_W-1:0] dev_addr,
    output logic [IDX_W-1:0] dev_next,
    output logic [IDX_W-1:0] dev_q
);

    localparam logic [IDX_W:0]   DEV_LIMIT = (IDX_W+1)'(NUM_DEV);
    localparam logic [IDX_W-1:0] DEV_LAST  = IDX_W'(NUM_DEV - 1);

    logic addr_ok;

    // Address range test for direct selection.
    always_comb begin
        addr_ok = ({1'b0, dev_addr} < DEV_LIMIT);
    end

    // Next device: wrap step when polled, strobe load when direct.
    always_comb begin
        dev_next = dev_q;
        if (mode == SCAN_POLLED) begin
            dev_next = (dev_q == DEV_LAST) ? '0 : dev_q + 1'b1;
        end else if (strobe && addr_ok) begin
            dev_next = dev_addr;
        end
    end

    // Device index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q <= '0;
        end else begin
            dev_q <= dev_next;
        end
    end

endmodule

// File: rtl/afs_group_mux.sv
// Module: picks the flag nibble of the device that becomes current at the
// coming edge and registers it. It also registers the one-hot drive enable.
// Assumes: dev_sel is always below NUM_DEV.
module afs_group_mux
    import afs_pkg::*;
#(
    parameter int unsigned NUM_DEV = 5,
    parameter int unsigned IDX_W   = $clog2(NUM_DEV),
    parameter int unsigned Q_W     = QUEUES_PER_DEV,
    parameter int unsigned TOTAL   = NUM_DEV * Q_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOTAL-1:0] flags_n,
    input  logic [IDX_W-1:0] dev_sel,
    output logic [Q_W-1:0]   bus_flags_n,
    output logic [NUM_DEV-1:0] bus_oe
);

    logic [NUM_DEV-1:0] hit;
    logic [Q_W-1:0]     nib [NUM_DEV];
    logic [Q_W-1:0]     bus_next;

    // Per-device decode and flag slice.
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        assign hit[d] = (dev_sel == IDX_W'(d));
        assign nib[d] = flags_n[d*Q_W +: Q_W];

        // Drive-enable bit for this device.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bus_oe[d] <= (d == 0);
            end else begin
                bus_oe[d] <= hit[d];
            end
        end
    end

    // Select the nibble of the chosen device (idle high if none).
    always_comb begin
        bus_next = '1;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (hit[d]) begin
                bus_next = nib[d];
            end
        end
    end

    // Registered status bus, all flags inactive after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_flags_n <= '1;
        end else begin
            bus_flags_n <= bus_next;
        end
    end

endmodule

// File: rtl/afs_queue_pick.sv
// Module: follows the flag of one queue across all devices. A select
// enable with an in-range queue number loads the choice. Out-of-range
// numbers are dropped.
// Assumes: TOTAL >= 2.
module afs_queue_pick #(
    parameter int unsigned TOTAL = 20,
    parameter int unsigned SEL_W = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_en,
    input  logic [SEL_W-1:0] sel_addr,
    input  logic [TOTAL-1:0] flags_n,
    output logic [SEL_W-1:0] sel_q,
    output logic             single_flag_n
);

    localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W+1)'(TOTAL);

    logic [SEL_W-1:0] sel_next;

    // Next selected queue.
    always_comb begin
        sel_next = sel_q;
        if (sel_en && ({1'b0, sel_addr} < SEL_LIMIT)) begin
            sel_next = sel_addr;
        end
    end

    // Selection and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q         <= '0;
            single_flag_n <= 1'b1;
        end else begin
            sel_q         <= sel_next;
            single_flag_n <= flags_n[sel_next];
        end
    end

endmodule

// File: rtl/afs_status_top.sv
// Module: top of the almost-flag status reporter. It joins the mode latch,
// the device sequencer, the bus mux and the single-queue picker.
// Assumes: one clock, synchronous active-low master reset.
module afs_status_top
    import afs_pkg::*;
#(
    parameter int unsigned NUM_DEV = 5,
    parameter int unsigned IDX_W   = $clog2(NUM_DEV),
    parameter int unsigned Q_W     = QUEUES_PER_DEV,
    parameter int unsigned TOTAL   = NUM_DEV * Q_W,
    parameter int unsigned SEL_W   = $clog2(TOTAL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_in,
    input  logic               strobe,
    input  logic [IDX_W-1:0]   dev_addr,
    input  logic               sel_en,
    input  logic [SEL_W-1:0]   sel_addr,
    input  logic [TOTAL-1:0]   flags_n,
    output logic [Q_W-1:0]     bus_flags_n,
    output logic [NUM_DEV-1:0] bus_oe,
    output logic [IDX_W-1:0]   bus_dev,
    output logic               single_flag_n
);

    scan_mode_e       mode_q;
    logic [IDX_W-1:0] dev_next;
    logic [SEL_W-1:0] sel_q;

    afs_mode_latch u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (mode_in),
        .mode_q  (mode_q)
    );

    afs_dev_sequencer #(
        .NUM_DEV (NUM_DEV),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .strobe   (strobe),
        .dev_addr (dev_addr),
        .dev_next (dev_next),
        .dev_q    (bus_dev)
    );

    afs_group_mux #(
        .NUM_DEV (NUM_DEV),
        .IDX_W   (IDX_W),
        .Q_W     (Q_W),
        .TOTAL   (TOTAL)
    ) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .flags_n     (flags_n),
        .dev_sel     (dev_next),
        .bus_flags_n (bus_flags_n),
        .bus_oe      (bus_oe)
    );

    afs_queue_pick #(
        .TOTAL (TOTAL),
        .SEL_W (SEL_W)
    ) u_pick (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_en        (sel_en),
        .sel_addr      (sel_addr),
        .flags_n       (flags_n),
        .sel_q         (sel_q),
        .single_flag_n (single_flag_n)
    );

endmodule

// File: rtl/afs_status_chk.sv
// Module: property checker for afs_status_top, attached with bind.
// Assumes: the same synchronous active-low reset as the design.
module afs_status_chk
    import afs_pkg::*;
#(
    parameter int unsigned NUM_DEV = 5,
    parameter int unsigned IDX_W   = $clog2(NUM_DEV),
    parameter int unsigned TOTAL   = NUM_DEV * QUEUES_PER_DEV,
    parameter int unsigned SEL_W   = $clog2(TOTAL)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               strobe,
    input logic [IDX_W-1:0]   dev_addr,
    input logic               sel_en,
    input logic [SEL_W-1:0]   sel_addr,
    input scan_mode_e         mode_q,
    input logic [IDX_W-1:0]   bus_dev,
    input logic [NUM_DEV-1:0] bus_oe,
    input logic [SEL_W-1:0]   sel_q
);

    localparam logic [IDX_W-1:0] DEV_LAST  = IDX_W'(NUM_DEV - 1);
    localparam logic [IDX_W:0]   DEV_LIMIT = (IDX_W+1)'(NUM_DEV);
    localparam logic [SEL_W:0]   SEL_LIMIT = (SEL_W+1)'(TOTAL);

    AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q)); // R1

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_q == SCAN_DIRECT && $past(strobe)
         && ({1'b0, $past(dev_addr)} < DEV_LIMIT)) |-> bus_dev == $past(dev_addr)); // R3

    AST_DIRECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_q == SCAN_DIRECT
         && (!$past(strobe) || ({1'b0, $past(dev_addr)} >= DEV_LIMIT))) |-> $stable(bus_dev)); // R4

    AST_POLL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_q == SCAN_POLLED) |->
        bus_dev == (($past(bus_dev) == DEV_LAST) ? '0 : $past(bus_dev) + 1'b1)); // R5

    AST_OE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(bus_oe) == 1 && bus_oe[bus_dev])); // R7

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_en) && ({1'b0, $past(sel_addr)} < SEL_LIMIT))
        |-> sel_q == $past(sel_addr)); // R8

    AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!$past(sel_en) || ({1'b0, $past(sel_addr)} >= SEL_LIMIT)))
        |-> $stable(sel_q)); // R9

endmodule

bind afs_status_top afs_status_chk #(
    .NUM_DEV (NUM_DEV),
    .IDX_W   (IDX_W),
    .TOTAL   (TOTAL),
    .SEL_W   (SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .dev_addr (dev_addr),
    .sel_en   (sel_en),
    .sel_addr (sel_addr),
    .mode_q   (mode_q),
    .bus_dev  (bus_dev),
    .bus_oe   (bus_oe),
    .sel_q    (sel_q)
);

// File: tb/sim_afs_status_top.sv
// Bench: behavioural reference model, compared on every clock.
module sim_afs_status_top;

    localparam int N   = 5;
    localparam int Q   = 4;
    localparam int TOT = N * Q;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode_in = 1'b0;
    logic            strobe = 1'b0;
    logic [2:0]      dev_addr = '0;
    logic            sel_en = 1'b0;
    logic [4:0]      sel_addr = '0;
    logic [TOT-1:0]  flags_n = '1;
    logic [Q-1:0]    bus_flags_n;
    logic [N-1:0]    bus_oe;
    logic [2:0]      bus_dev;
    logic            single_flag_n;

    int total = 0;
    int bad   = 0;

    // Model state
    int m_mode = 0;
    int m_dev = 0;
    int m_bus = 15;
    int m_sel = 0;
    int m_single = 1;

    always #4 clk = ~clk;

    afs_status_top u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_in       (mode_in),
        .strobe        (strobe),
        .dev_addr      (dev_addr),
        .sel_en        (sel_en),
        .sel_addr      (sel_addr),
        .flags_n       (flags_n),
        .bus_flags_n   (bus_flags_n),
        .bus_oe        (bus_oe),
        .bus_dev       (bus_dev),
        .single_flag_n (single_flag_n)
    );

    // Reference model, updated from the inputs held stable at the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = int'(mode_in);
            m_dev = 0; m_bus = 15; m_sel = 0; m_single = 1;
        end else begin
            if (m_mode == 1) m_dev = (m_dev + 1) % N;
            else if (strobe && int'(dev_addr) < N) m_dev = int'(dev_addr);
            m_bus = 0;
            for (int q = 0; q < Q; q++) m_bus = m_bus | (int'(flags_n[m_dev*Q+q]) << q);
            if (sel_en && int'(sel_addr) < TOT) m_sel = int'(sel_addr);
            m_single = int'(flags_n[m_sel]);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string dev_req);
        check(dev_req, int'(bus_dev), m_dev);
        check("R6 bus flags", int'(bus_flags_n), m_bus);
        check("R7 drive enable", int'(bus_oe), 1 << m_dev);
        check("R8 single flag", int'(single_flag_n), m_single);
    endtask

    task automatic randomize_inputs();
        strobe   = ($urandom % 3) == 0;
        dev_addr = 3'($urandom);
        sel_en   = ($urandom % 4) == 0;
        sel_addr = 5'($urandom);
        flags_n  = TOT'($urandom);
        mode_in  = 1'($urandom);   // R1: must be ignored outside reset
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n = 1'b0; mode_in = m; strobe = 1'b1; dev_addr = 3'd3; flags_n = '0;
        repeat (2) @(negedge clk);
        // R2: state right after reset edges
        check("R2 dev", int'(bus_dev), 0);
        check("R2 bus", int'(bus_flags_n), 15);
        check("R2 oe", int'(bus_oe), 1);
        check("R2 single", int'(single_flag_n), 1);
        rst_n = 1'b1; mode_in = ~m;
    endtask

    task automatic run_random(input int cycles, input string dev_req);
        for (int i = 0; i < cycles; i++) begin
            randomize_inputs();
            @(negedge clk);
            compare_all(dev_req);
        end
    endtask

    initial begin
        // Direct mode
        do_reset(1'b0);
        strobe = 1'b1; dev_addr = 3'd2; flags_n = TOT'(20'h00A00);
        @(negedge clk);
        check("R3 direct load", int'(bus_dev), 2);
        check("R6 nibble", int'(bus_flags_n), 4'hA);
        strobe = 1'b1; dev_addr = 3'd7;
        @(negedge clk);
        check("R4 out-of-range addr", int'(bus_dev), 2);
        strobe = 1'b0; dev_addr = 3'd4;
        @(negedge clk);
        check("R4 no strobe", int'(bus_dev), 2);
        sel_en = 1'b1; sel_addr = 5'd9; flags_n = '1; flags_n[9] = 1'b0;
        @(negedge clk);
        check("R8 single select", int'(single_flag_n), 0);
        sel_addr = 5'd31; flags_n = '0; flags_n[9] = 1'b1;
        @(negedge clk);
        check("R9 out-of-range select", int'(single_flag_n), 1);
        sel_en = 1'b0;
        run_random(400, "R3 R4 direct device");
        check("R1 mode stays direct", m_mode, 0);

        // Polled mode
        do_reset(1'b1);
        strobe = 1'b1; dev_addr = 3'd3;
        for (int k = 1; k <= 2 * N; k++) begin
            @(negedge clk);
            check("R5 poll step", int'(bus_dev), k % N);
        end
        run_random(400, "R5 polled device");
        check("R1 mode stays polled", m_mode, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule